// File: doc/BRIEF.md
# Heartbeat Watchdog with Float Disable

This block watches a heartbeat line that processor software toggles. If no transition of either polarity arrives for a set number of clock cycles, it drives an active-low alarm flag. Both a rising and a falling heartbeat transition restart the timer. The alarm flag can be routed to a non-maskable interrupt, or back into the reset generator's manual input so that a stalled processor is restarted.

Three side conditions shape the alarm:
- **System reset:** while system reset is active, the timer is held at zero.
- **Heartbeat floating:** a separate digital flag reports that the heartbeat line is floating, because the line is undriven or tri-stated. While that flag is set, the timer is disabled and held at zero.
- **Supply low:** a supply-low indication pulls the alarm low at once, whatever the timer holds.

With the heartbeat floating, the alarm therefore acts as a plain low-supply warning.

The timeout is a parameter counted in clock cycles. The default is 400,000,000 cycles, which is 1.6 s at 250 MHz. Any setting that falls within 1.0 s to 2.25 s of real time is acceptable.

The heartbeat input is asynchronous. It is brought into the clock domain through a two-flop synchronizer. The floating, system-reset and supply-low flags are taken as synchronous to the clock. No data stream passes through the block, so every pin is a plain level signal with no handshake.

Top module: `wdg_top`

## Requirements
- R1: After the asynchronous reset `rst_n` releases, with `supply_low_i` at 0, `wdo_n_o` reads 1.
- R2: Let TIMEOUT_CYC rising clock edges pass with no clear, meaning `sys_rst_i`, `hb_float_i` and heartbeat transitions are all absent. `wdo_n_o` then goes to 0 right after edge number TIMEOUT_CYC, and not earlier.
- R3: A transition on `hb_i` of either polarity restarts the count. The restart takes effect on the third rising clock edge after the input changes (two synchronizer flops plus the counter). A full TIMEOUT_CYC edges must then pass before the next alarm.
- R4: While `sys_rst_i` is 1, the count is held at zero and no alarm occurs. Timing starts with the first clock edge at which `sys_rst_i` is 0.
- R5: Once raised, the alarm stays at 0 until a clear occurs. The counter saturates at the terminal count and never wraps, so the alarm persists for any length of time. A supply-low episode during the alarm does not end it.
- R6: `supply_low_i` = 1 forces `wdo_n_o` to 0 in the same cycle, whatever the count. When `supply_low_i` returns to 0 and the timer has not expired, `wdo_n_o` returns to 1 in the same cycle.
- R7: While `hb_float_i` is 1, the timer is disabled. `wdo_n_o` then equals the inverse of `supply_low_i`, even if the timer had expired before the flag rose.
- R8: While `hb_float_i` is 1, the count is held at zero. When the flag falls, a full TIMEOUT_CYC edges pass before an alarm.
- R9: A heartbeat level held for a single clock period is seen as two transitions and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| hb_i | input | 1 | Heartbeat line from the processor, asynchronous |
| hb_float_i | input | 1 | 1 when the heartbeat line is undriven or tri-stated |
| sys_rst_i | input | 1 | 1 while the system reset is active |
| supply_low_i | input | 1 | 1 while the supply is below its threshold |
| wdo_n_o | output | 1 | Active-low watchdog alarm |

## Verification
The hardest situations to reach are those where the synchronizer pipeline and the counter interact:
- **One-clock heartbeat pulse:** the pulse yields two detected transitions.
- **Restart with an expired or nearly expired count:** a restart that lands on such a count must not let one alarm cycle leak through.

The stimulus runs the counter to a known count a few cycles short of expiry after a system-reset release. It then drives a one-cycle pulse, so that a missed restart would show as an alarm within five cycles.

Leaving the floating state is reached by holding the flag for several timeout lengths. This shows that the count is not merely frozen while floating. After the flag drops, a full timeout must pass again.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // Number of synchronizer flops in front of edge detection.
  localparam int SYNC_STAGES = 2;

  // Bits needed to hold a count of 0..t inclusive.
  function automatic int cnt_width(input int t);
    return (t < 2) ? 1 : $clog2(t + 1);
  endfunction
endpackage

// File: rtl/wdg_edge.sv
// Synchronizes an asynchronous level and flags any change of it.
module wdg_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic toggle
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign toggle = sh_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/wdg_timer.sv
// Saturating up-counter with synchronous clear.
module wdg_timer #(
  parameter int TIMEOUT_CYC = 400_000_000,
  parameter int CW          = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [CW-1:0] cnt_q,
  output logic          expired
);
  localparam logic [CW-1:0] TERM = CW'(TIMEOUT_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (cnt_q != TERM) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign expired = (cnt_q == TERM);
endmodule

// File: rtl/wdg_top.sv
module wdg_top #(
  parameter int TIMEOUT_CYC = 400_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_i,
  input  logic hb_float_i,
  input  logic sys_rst_i,
  input  logic supply_low_i,
  output logic wdo_n_o
);
  localparam int CW = wdg_pkg::cnt_width(TIMEOUT_CYC);

  logic          hb_toggle;
  logic          tmr_clear;
  logic          tmr_expired;
  logic [CW-1:0] cnt_q;

  wdg_edge #(.STAGES(wdg_pkg::SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (hb_i),
    .toggle (hb_toggle)
  );

  // Floating holds the count clear, so leaving it starts from zero.
  assign tmr_clear = sys_rst_i | hb_float_i | hb_toggle;

  wdg_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmr_clear),
    .cnt_q   (cnt_q),
    .expired (tmr_expired)
  );

  assign wdo_n_o = ~(supply_low_i | (tmr_expired & ~hb_float_i));
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
  parameter int TIMEOUT_CYC = 400_000_000,
  parameter int CW          = 29
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hb_float_i,
  input logic          sys_rst_i,
  input logic          supply_low_i,
  input logic          wdo_n_o,
  input logic [CW-1:0] cnt_q
);
  localparam logic [CW-1:0] TERM = CW'(TIMEOUT_CYC);

  AST_SUPPLY_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low_i |-> !wdo_n_o);  // R6
  AST_FLOAT_NO_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_float_i && !supply_low_i) |-> wdo_n_o);  // R7
  AST_SYSRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_i |=> (cnt_q == '0));  // R4
  AST_FLOAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hb_float_i |=> (cnt_q == '0));  // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TERM) |=> (cnt_q == TERM || cnt_q == '0));  // R5
endmodule

bind wdg_top wdg_chk #(.TIMEOUT_CYC(TIMEOUT_CYC), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hb_float_i   (hb_float_i),
  .sys_rst_i    (sys_rst_i),
  .supply_low_i (supply_low_i),
  .wdo_n_o      (wdo_n_o),
  .cnt_q        (cnt_q)
);

// File: tb/sim_wdg_top.sv
`timescale 1ns/1ps
module sim_wdg_top;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hb = 1'b0;
  logic hb_float = 1'b0;
  logic sys_rst = 1'b1;
  logic supply_low = 1'b0;
  logic wdo_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic  val;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  wdg_top #(.TIMEOUT_CYC(T)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .hb_i         (hb),
    .hb_float_i   (hb_float),
    .sys_rst_i    (sys_rst),
    .supply_low_i (supply_low),
    .wdo_n_o      (wdo_n)
  );

  // Driver: queue the expected alarm for the next n edges, then let them pass.
  task automatic run(input int n, input logic v, input string tag);
    for (int i = 0; i < n; i++) sb.push_back('{val: v, tag: tag});
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare one expectation per clock edge, away from the edge.
  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (wdo_n !== e.val) begin
        fails++;
        $display("FAIL %s: wdo_n_o actual %0b expected %0b at %0t",
                 e.tag, wdo_n, e.val, $time);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(1, 1'b1, "R1");
    run(25, 1'b1, "R4");                 // held clear in system reset
    sys_rst = 1'b0;
    run(T-1, 1'b1, "R2");
    run(1, 1'b0, "R2");
    run(3*T, 1'b0, "R5");                // saturates, no wrap
    hb = 1'b1;                           // rising heartbeat edge
    run(2, 1'b0, "R3");
    run(1, 1'b1, "R3");
    run(T-1, 1'b1, "R3");
    run(2, 1'b0, "R3");
    hb = 1'b0;                           // falling heartbeat edge
    run(2, 1'b0, "R3");
    run(1, 1'b1, "R3");
    for (int k = 0; k < 4; k++) begin    // regular heartbeat keeps it quiet
      hb = ~hb;
      run(10, 1'b1, "R3");
    end
    sys_rst = 1'b1;
    run(2, 1'b1, "R4");
    sys_rst = 1'b0;
    run(15, 1'b1, "R9");
    hb = ~hb;                            // one-cycle pulse
    run(1, 1'b1, "R9");
    hb = ~hb;
    run(14, 1'b1, "R9");
    sys_rst = 1'b1;
    run(2, 1'b1, "R4");
    supply_low = 1'b1;
    run(3, 1'b0, "R6");
    supply_low = 1'b0;
    run(2, 1'b1, "R6");
    sys_rst = 1'b0;
    hb_float = 1'b1;
    run(3*T, 1'b1, "R7");
    supply_low = 1'b1;
    run(2, 1'b0, "R7");
    supply_low = 1'b0;
    run(1, 1'b1, "R7");
    hb_float = 1'b0;
    run(T-1, 1'b1, "R8");
    run(2, 1'b0, "R8");
    supply_low = 1'b1;
    run(2, 1'b0, "R6");
    supply_low = 1'b0;
    run(2, 1'b0, "R5");                  // still expired after supply recovers
    hb_float = 1'b1;
    run(3, 1'b1, "R7");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule